// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between an on-chip request bus and an external asynchronous static RAM of 32K bytes. It takes one request at a time, either a read or a write of one byte, over a valid/ready handshake. It then plays out the strobe sequence the memory needs. Chip select, write strobe and output strobe are all active low. Each phase lasts a whole number of system clock cycles. That number is worked out when the block is elaborated, from the memory's nanosecond figures and the clock period.

The data bus is split into three signals: an outgoing byte, a drive enable and an incoming byte. The pad ring joins them into the shared bidirectional pins. A read keeps chip select and the output strobe low for the access time. The byte is captured on the edge that ends that window and comes back with a one-cycle valid pulse. A turnaround gap follows every read, so the memory has let go of the bus before the controller drives it again. A write keeps the output strobe high throughout and drives data for the whole write-strobe window. It keeps driving for one extra cycle after the write strobe rises, and only then releases the bus. Between accesses the memory is deselected so it stays in standby.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted and directly after it, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `rdata_valid` is 0 and `req_ready` is 1.
- R2: Whenever `req_ready` is 1 (no access in progress), all three strobes are 1 and `mem_dq_oe` is 0, so the memory is deselected and in standby.
- R3: A read (`req_we`=0) drives `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for RD_CYC = ceil(T_RD_NS/CLK_NS) cycles (2 at defaults), starting with the cycle after acceptance. `mem_dq_in` is sampled on the edge that ends this window. The sampled byte appears on `rdata` together with a single-cycle `rdata_valid` pulse, RD_CYC cycles after the accepting edge.
- R4: A write (`req_we`=1) keeps `mem_oe_n`=1 and holds `mem_we_n`=0 with `mem_ce_n`=0 for WP_CYC = ceil(max(T_WP_NS,T_DS_NS)/CLK_NS) cycles (1 at defaults). Through that window `mem_dq_oe`=1 and `mem_dq_out` equals the request's `req_wdata`. The memory then holds that byte at `req_addr`.
- R5: For exactly one cycle after `mem_we_n` returns to 1, `mem_ce_n` stays 0, the address stays the same and `mem_dq_oe` stays 1. In the cycle after that the bus is released and the chip is deselected.
- R6: The controller never drives the bus while the memory may be driving it. `mem_dq_oe`=1 only when `mem_oe_n`=1, and only when at least TURN_CYC = ceil(T_TURN_NS/CLK_NS) cycles (1 at defaults) have passed since `mem_oe_n` last rose.
- R7: After each read, all strobes stay high for TURN_CYC cycles before the next request can be accepted. A read therefore keeps `req_ready` low for RD_CYC+TURN_CYC cycles, and a write keeps it low for WP_CYC+1 cycles.
- R8: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 in the following cycle.
- R9: `mem_addr` does not change while `mem_ce_n` stays 0 from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| rdata | output | DATA_W | Read byte |
| rdata_valid | output | 1 | One-cycle pulse marking `rdata` |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_dq_out | output | DATA_W | Byte driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | DATA_W | Byte read from the data pins |

## Verification
The bench pairs the controller with a memory model. The model returns a placeholder byte until the access time has really passed, checks write-strobe width and data setup in nanoseconds, and keeps watch for both sides driving the bus. Writes use all-zeros, all-ones and alternating patterns at the lowest and highest addresses. These show whether the stored byte and the address pins are intact at the range ends, and whether any data bit is stuck or swapped. Read-after-read, write-after-read and overwrite sequences test the turnaround gap and the busy window. A read sampled one cycle early returns the placeholder byte rather than the stored one, so an access-time error shows up as wrong data.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_READ   = 3'd1,
      ST_TURN   = 3'd2,
      ST_WPULSE = 3'd3,
      ST_WHOLD  = 3'd4
   } sram_st_e;

   typedef struct packed {
      logic ce_n;
      logic we_n;
      logic oe_n;
      logic drive;
   } pin_t;

   // whole cycles covering a nanosecond figure, never less than one
   function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
      int unsigned c;
      c = (ns + clk_ns - 1) / clk_ns;
      return (c == 0) ? 1 : c;
   endfunction

   // pin levels that go with each state
   function automatic pin_t pins_of(sram_st_e s);
      pin_t p;
      case (s)
         ST_READ:   p = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, drive: 1'b0};
         ST_WPULSE: p = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, drive: 1'b1};
         ST_WHOLD:  p = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b1};
         default:   p = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
      endcase
      return p;
   endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/1ps
module sram_ctl_fsm
   import sram_ctl_pkg::*;
#(
   parameter int unsigned RD_CYC   = 2,
   parameter int unsigned WP_CYC   = 1,
   parameter int unsigned TURN_CYC = 1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     acc,
   input  logic     acc_we,
   output sram_st_e state_q,
   output sram_st_e state_d,
   output logic     cap_en
);

   localparam int unsigned MAX_AB = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
   localparam int unsigned MAXC   = (MAX_AB > TURN_CYC) ? MAX_AB : TURN_CYC;
   localparam int unsigned CNT_W  = (MAXC > 1) ? $clog2(MAXC) : 1;

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             cnt_zero;

   assign cnt_zero = (cnt_q == '0);
   assign cap_en   = (state_q == ST_READ) && cnt_zero;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_zero ? cnt_q : cnt_q - 1'b1;
      case (state_q)
         ST_IDLE: begin
            if (acc) begin
               if (acc_we) begin
                  state_d = ST_WPULSE;
                  cnt_d   = CNT_W'(WP_CYC - 1);
               end else begin
                  state_d = ST_READ;
                  cnt_d   = CNT_W'(RD_CYC - 1);
               end
            end
         end
         ST_READ: begin
            if (cnt_zero) begin
               state_d = ST_TURN;
               cnt_d   = CNT_W'(TURN_CYC - 1);
            end
         end
         ST_TURN:   if (cnt_zero) state_d = ST_IDLE;
         ST_WPULSE: if (cnt_zero) state_d = ST_WHOLD;
         ST_WHOLD:  state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

endmodule

// File: rtl/sram_ctl_pins.sv
`timescale 1ns/1ps
module sram_ctl_pins
   import sram_ctl_pkg::*;
#(
   parameter int unsigned AW = 15,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  sram_st_e      state_d,
   input  logic          acc,
   input  logic [AW-1:0] addr_in,
   input  logic [DW-1:0] wdata_in,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_dq_out,
   output logic          mem_ce_n,
   output logic          mem_we_n,
   output logic          mem_oe_n,
   output logic          mem_dq_oe
);

   pin_t p_d;
   assign p_d = pins_of(state_d);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_ce_n   <= 1'b1;
         mem_we_n   <= 1'b1;
         mem_oe_n   <= 1'b1;
         mem_dq_oe  <= 1'b0;
         mem_addr   <= '0;
         mem_dq_out <= '0;
      end else begin
         mem_ce_n  <= p_d.ce_n;
         mem_we_n  <= p_d.we_n;
         mem_oe_n  <= p_d.oe_n;
         mem_dq_oe <= p_d.drive;
         if (acc) begin
            mem_addr   <= addr_in;
            mem_dq_out <= wdata_in;
         end
      end
   end

endmodule

// File: rtl/sram_ctl_rdcap.sv
`timescale 1ns/1ps
module sram_ctl_rdcap #(
   parameter int unsigned DW         = 8,
   parameter bit          HOLD_RDATA = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap_en,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] rdata,
   output logic          rdata_valid
);

   logic [DW-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q      <= '0;
         rdata_valid <= 1'b0;
      end else begin
         rdata_valid <= cap_en;
         if (cap_en) data_q <= din;
      end
   end

   generate
      if (HOLD_RDATA) begin : g_hold
         assign rdata = data_q;
      end else begin : g_mask
         assign rdata = rdata_valid ? data_q : '0;
      end
   endgenerate

endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
   import sram_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W     = 15,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned CLK_NS     = 10,
   parameter int unsigned T_RD_NS    = 12,
   parameter int unsigned T_WP_NS    = 8,
   parameter int unsigned T_DS_NS    = 7,
   parameter int unsigned T_TURN_NS  = 5,
   parameter bit          HOLD_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int unsigned WSTROBE_NS = (T_WP_NS > T_DS_NS) ? T_WP_NS : T_DS_NS;
   localparam int unsigned RD_CYC     = ns_to_cyc(T_RD_NS, CLK_NS);
   localparam int unsigned WP_CYC     = ns_to_cyc(WSTROBE_NS, CLK_NS);
   localparam int unsigned TURN_CYC   = ns_to_cyc(T_TURN_NS, CLK_NS);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_ctl: address and data widths must be at least one bit");
      end
      if (CLK_NS < 1) begin : g_bad_clk
         $error("sram_ctl: clock period must be a positive number of ns");
      end
   endgenerate

   sram_st_e state_q, state_d;
   logic     cap_en;
   logic     acc;

   assign req_ready = (state_q == ST_IDLE);
   assign acc       = req_valid && req_ready;

   sram_ctl_fsm #(
      .RD_CYC   (RD_CYC),
      .WP_CYC   (WP_CYC),
      .TURN_CYC (TURN_CYC)
   ) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc     (acc),
      .acc_we  (req_we),
      .state_q (state_q),
      .state_d (state_d),
      .cap_en  (cap_en)
   );

   sram_ctl_pins #(
      .AW (ADDR_W),
      .DW (DATA_W)
   ) u_pins (
      .clk        (clk),
      .rst_n      (rst_n),
      .state_d    (state_d),
      .acc        (acc),
      .addr_in    (req_addr),
      .wdata_in   (req_wdata),
      .mem_addr   (mem_addr),
      .mem_dq_out (mem_dq_out),
      .mem_ce_n   (mem_ce_n),
      .mem_we_n   (mem_we_n),
      .mem_oe_n   (mem_oe_n),
      .mem_dq_oe  (mem_dq_oe)
   );

   sram_ctl_rdcap #(
      .DW         (DATA_W),
      .HOLD_RDATA (HOLD_RDATA)
   ) u_rdcap (
      .clk         (clk),
      .rst_n       (rst_n),
      .cap_en      (cap_en),
      .din         (mem_dq_in),
      .rdata       (rdata),
      .rdata_valid (rdata_valid)
   );

endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
module sram_ctl_chk #(
   parameter int unsigned ADDR_W   = 15,
   parameter int unsigned WP_CYC   = 1,
   parameter int unsigned TURN_CYC = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rdata_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ce_n,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic              mem_dq_oe
);

   localparam logic [7:0] WP_L   = 8'(WP_CYC);
   localparam logic [7:0] TURN_L = 8'(TURN_CYC);

   logic [7:0] we_lo_cnt;
   logic [7:0] oe_hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_lo_cnt <= '0;
         oe_hi_cnt <= '1;
      end else begin
         if (mem_we_n)                we_lo_cnt <= '0;
         else if (we_lo_cnt != 8'hFF) we_lo_cnt <= we_lo_cnt + 8'd1;
         if (!mem_oe_n)               oe_hi_cnt <= '0;
         else if (oe_hi_cnt != 8'hFF) oe_hi_cnt <= oe_hi_cnt + 8'd1;
      end
   end

   // R2
   idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

   // R3
   rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_valid |=> !rdata_valid);

   // R4
   wr_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_oe_n && !mem_ce_n && mem_dq_oe));

   // R4
   wr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_lo_cnt >= WP_L));

   // R5
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n));

   // R6
   no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   // R6
   turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (oe_hi_cnt >= TURN_L));

   // R8
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R9
   addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

bind sram_ctl sram_ctl_chk #(
   .ADDR_W   (ADDR_W),
   .WP_CYC   (WP_CYC),
   .TURN_CYC (TURN_CYC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .rdata_valid (rdata_valid),
   .mem_addr    (mem_addr),
   .mem_ce_n    (mem_ce_n),
   .mem_we_n    (mem_we_n),
   .mem_oe_n    (mem_oe_n),
   .mem_dq_oe   (mem_dq_oe)
);

// File: tb/tb_sram_ctl.sv
`timescale 1ns/1ps
module tb_sram_ctl;

   localparam int RD_C   = 2;   // ceil(12/10)
   localparam int WP_C   = 1;   // ceil(max(8,7)/10)
   localparam int TURN_C = 1;   // ceil(5/10)

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_we = 1'b0;
   logic [14:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, rdata_valid;
   logic [7:0]  rdata;
   logic [14:0] mem_addr;
   logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [7:0]  mem_dq_out;
   logic [7:0]  mem_dq_in = 8'hEE;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sram_ctl dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
      .rdata(rdata), .rdata_valid(rdata_valid), .mem_addr(mem_addr),
      .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $realtime);
      end
   endtask

   // ---------------- memory model ----------------
   logic [7:0] marr [int];
   realtime t_chg = 0.0, t_we_fall = 0.0, t_dat = 0.0, t_oe_rise = -100.0;
   bit contention = 0;
   bit idle_bad   = 0;

   always @(mem_addr or mem_ce_n or mem_oe_n) t_chg = $realtime;
   always @(negedge mem_we_n) t_we_fall = $realtime;
   always @(mem_dq_out or posedge mem_dq_oe) t_dat = $realtime;
   always @(posedge mem_oe_n) t_oe_rise = $realtime;

   // write ends on the rising write strobe: check width and data setup
   always @(posedge mem_we_n) begin
      if (rst_n && !mem_ce_n) begin
         chk("R4 strobe width >= 8ns", 32'($realtime - t_we_fall >= 8.0), 1);
         chk("R4 data setup >= 7ns", 32'($realtime - t_dat >= 7.0), 1);
         chk("R5 data driven at strobe end", mem_dq_oe, 1);
         marr[int'(mem_addr)] = mem_dq_out;
      end
   end

   // read data appears only once the access time has passed at the next edge
   always @(negedge clk) begin
      bit mem_drv;
      mem_drv = !mem_ce_n && !mem_oe_n && mem_we_n;
      if (mem_drv && ($realtime + 5.0 - t_chg >= 12.0))
         mem_dq_in <= marr.exists(int'(mem_addr)) ? marr[int'(mem_addr)] : 8'h00;
      else
         mem_dq_in <= 8'hEE;
      if (rst_n && mem_dq_oe && (mem_drv || ($realtime - t_oe_rise < 5.0))) contention = 1;
      if (rst_n && req_ready && !(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe)) idle_bad = 1;
   end

   // ---------------- scoreboard ----------------
   typedef struct { logic [7:0] data; int acc_cyc; } exp_t;
   exp_t exp_q[$];
   logic [7:0] shadow [int];

   always @(negedge clk) begin
      if (rst_n && rdata_valid) begin
         if (exp_q.size() == 0) begin
            chk("R3 unexpected rdata_valid", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk("R3 read data", rdata, e.data);
            chk("R3 read latency", cyc - e.acc_cyc, RD_C);
         end
      end
   end

   // drive one request at a negedge; returns at the negedge after acceptance
   task automatic issue(bit we, logic [14:0] a, logic [7:0] d);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
   endtask

   task automatic do_write(logic [14:0] a, logic [7:0] d);
      issue(1'b1, a, d);
      for (int i = 0; i < WP_C; i++) begin
         chk("R4 we_n low", mem_we_n, 0);
         chk("R4 oe_n high", mem_oe_n, 1);
         chk("R4 data out", mem_dq_out, d);
         chk("R8 busy", req_ready, 0);
         if (i < WP_C - 1) @(negedge clk);
      end
      @(negedge clk);
      chk("R5 hold drive", {mem_we_n, mem_ce_n, mem_dq_oe}, 3'b101);
      chk("R5 hold addr", mem_addr, a);
      @(negedge clk);
      chk("R5 released", {mem_ce_n, mem_dq_oe}, 2'b10);
      chk("R7 write busy window", req_ready, 1);
      shadow[int'(a)] = d;
   endtask

   task automatic do_read(logic [14:0] a);
      exp_t e;
      issue(1'b0, a, 8'h00);
      e.data = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
      e.acc_cyc = cyc;
      exp_q.push_back(e);
      chk("R3 read strobes", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b001);
      chk("R3 read addr", mem_addr, a);
      chk("R8 busy", req_ready, 0);
      repeat (RD_C) @(negedge clk);
      chk("R7 turnaround strobes high", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
      chk("R7 not ready in turnaround", req_ready, 0);
      repeat (TURN_C) @(negedge clk);
      chk("R7 read busy window", req_ready, 1);
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         report();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      chk("R1 strobes in reset", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
      chk("R1 no drive in reset", mem_dq_oe, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready after reset", req_ready, 1);
      chk("R1 rdata_valid after reset", rdata_valid, 0);
      chk("R2 idle deselected", mem_ce_n, 1);

      do_write(15'h0000, 8'h00);
      do_write(15'h7FFF, 8'hFF);
      do_write(15'h0155, 8'hA5);
      do_write(15'h2AAA, 8'h5A);
      do_read(15'h0000);
      do_read(15'h7FFF);     // read after read
      do_write(15'h0001, 8'h3C); // write after read: turnaround
      do_read(15'h0155);
      do_read(15'h2AAA);
      do_read(15'h0001);
      do_write(15'h0155, 8'hC3); // overwrite
      do_write(15'h0155, 8'h96);
      do_read(15'h0155);
      repeat (4) @(negedge clk);
      chk("R2 idle deselected", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
      chk("R3 all reads returned", exp_q.size(), 0);
      chk("R6 no bus contention", contention, 0);
      chk("R2 idle pins whenever ready", idle_bad, 0);
      chk("R9 last address held", mem_addr, 15'h0155);
      done = 1;
      report();
   end

endmodule